// File: doc/BRIEF.md
# DDR Read Burst Output Sequencer With Precharge Truncation

This block models the memory side of a DDR SDRAM read: the path that turns a read command into a timed burst of data words and a data strobe. A read command, sampled on a rising clock edge together with a starting column, starts a fixed latency of `CL` cycles. The strobe is driven low for one preamble cycle. Data words then leave in pairs, one pair per clock cycle, standing for the rising-half and falling-half transfers of a double-data-rate bus. A precharge command to the same bank may arrive while the burst is still pending or in flight. In that case the output turns off exactly `CL` cycles after the precharge, so the burst is cut at a whole-cycle boundary. Once the last word has gone out, the data and strobe lanes go to high impedance.

The design runs on a single clock. It counts words in steps of two per cycle, so no falling-edge logic is needed. The enables are registered, and a thin pad wrapper turns them into tristate lanes. The data come from a pattern generator: word number k of a burst started at column `c` has the value `c + k`, modulo 2^W.

The sequencer has four states. `ST_IDLE` waits for a read. `ST_WAIT` counts out the latency. `ST_PRE` is the strobe preamble. `ST_BURST` sends the word pairs. Its transitions are:
- IDLE→WAIT when a read is accepted.
- WAIT→PRE when the latency count reaches zero.
- PRE→BURST on the following edge.
- BURST→IDLE on the last pair or on a precharge cut.

Top module: `ddr_read_burst_out`

## Requirements
- R1: While and directly after reset, `dq_oe`, `dqs_oe` and `pre_illegal` are low.
- R2: For a read accepted on edge t, the cycle after edge t+CL-1 is a preamble: `dqs_oe`=1, `dqs_pad`=2'b00, `dq_oe`=0.
- R3: For a full burst, in the cycles after edges t+CL through t+CL+BL/2-1, `dq_oe`=1 and `dqs_pad`=2'b10 ({rising half, falling half}). In the k-th such cycle (k from 0), `dq_rise_pad`=col+2k and `dq_fall_pad`=col+2k+1, modulo 2^W.
- R4: After a full burst, `dq_oe` and `dqs_oe` are low from edge t+CL+BL/2 onward.
- R5: A precharge on edge t+d, with 1 ≤ d < BL/2, leaves the words unchanged up to edge t+d+CL-1 and turns both enables off from edge t+d+CL onward.
- R6: A precharge on edge t+d with d ≥ BL/2 does not shorten the burst.
- R7: A precharge asserted on the same edge as a read is ignored, and `pre_illegal` is high for exactly the following cycle. `pre_illegal` is low after every other edge.
- R8: A precharge while no read is pending or in flight has no effect: no output is enabled and no flag is raised.
- R9: A read command while a burst is pending or in flight is ignored. The burst keeps its column and its end cycle.
- R10: Once a precharge has been accepted, later precharges in the same burst are ignored, so the earliest one sets the cut.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_cmd | input | 1 | Read command |
| pre_cmd | input | 1 | Precharge command to the same bank |
| rd_col | input | W | Starting column, sampled with `rd_cmd` |
| dq_rise_pad | output | W | Rising-half data word, high impedance when disabled |
| dq_fall_pad | output | W | Falling-half data word, high impedance when disabled |
| dqs_pad | output | 2 | Strobe levels {rising half, falling half}, high impedance when disabled |
| dq_oe | output | 1 | Registered data output enable |
| dqs_oe | output | 1 | Registered strobe output enable |
| pre_illegal | output | 1 | One-cycle flag for a precharge that coincides with a read |

## Verification
The embedded assertions check four things on every cycle: the data enable never stands without the strobe enable, every data run starts right after a strobe preamble, the word index rises by two inside a run, and no run is longer than BL/2 cycles. They also check that the illegal flag only follows a coinciding read and precharge. The exact cut cycle for each precharge offset, the word values, and the fact that ignored commands (late reads, repeated or idle precharges) leave the burst untouched can only be shown by the bench. It sweeps every precharge offset from one cycle after the read to past the natural end, for several columns including one that wraps.

// File: rtl/ddrrd_pkg.sv
package ddrrd_pkg;

    // Sequencer states for one read burst
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_PRE   = 2'd2,
        ST_BURST = 2'd3
    } rd_state_e;

    // Strobe levels {rising half, falling half}
    localparam logic [1:0] STROBE_DATA = 2'b10;
    localparam logic [1:0] STROBE_LOW  = 2'b00;

endpackage

// File: rtl/ddrrd_cut.sv
module ddrrd_cut #(
    parameter int CL = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic rd_cmd,
    input  logic pre_cmd,
    output logic cut_now,
    output logic illegal_q
);
    localparam int LW = $clog2(CL) + 1;

    logic          armed_q;
    logic [LW-1:0] cnt_q;
    logic          pre_ok;

    // Accept only a clean precharge during a burst, and only the first one
    assign pre_ok  = pre_cmd && !rd_cmd && live && !armed_q;
    assign cut_now = armed_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            cnt_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= rd_cmd && pre_cmd;
            if (!live) begin
                armed_q <= 1'b0;
            end else if (pre_ok) begin
                armed_q <= 1'b1;
                cnt_q   <= LW'(CL - 1);
            end else if (armed_q && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_CUT_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(armed_q)) |-> $past(live && pre_cmd)); // R10

endmodule

// File: rtl/ddrrd_pattern.sv
module ddrrd_pattern #(
    parameter int W  = 16,
    parameter int IW = 3
) (
    input  logic [W-1:0]  col,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  word_rise,
    output logic [W-1:0]  word_fall
);
    logic [W-1:0] idx_w;

    assign idx_w     = {{(W-IW){1'b0}}, idx};
    assign word_rise = col + idx_w;
    assign word_fall = col + idx_w + W'(1);

endmodule

// File: rtl/ddrrd_seq.sv
module ddrrd_seq
    import ddrrd_pkg::*;
#(
    parameter int W  = 16,
    parameter int CL = 3,
    parameter int BL = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_cmd,
    input  logic [W-1:0]          rd_col,
    input  logic                  cut_now,
    output logic                  live,
    output logic [W-1:0]          col_q,
    output logic [$clog2(BL)-1:0] idx_q,
    output logic                  dq_oe_q,
    output logic                  dqs_oe_q,
    output logic [1:0]            dqs_q
);
    localparam int IW    = $clog2(BL);
    localparam int LW    = $clog2(CL) + 1;
    localparam int BEATS = BL / 2;

    rd_state_e     state_q, state_n;
    logic [LW-1:0] lat_q, lat_n;
    logic [IW-1:0] idx_n;
    logic [W-1:0]  col_n;
    logic [IW:0]   run_q;

    assign live = (state_q != ST_IDLE);

    // Next-state logic
    always_comb begin
        state_n = state_q;
        lat_n   = lat_q;
        idx_n   = idx_q;
        col_n   = col_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_cmd) begin
                    state_n = ST_WAIT;
                    lat_n   = LW'(CL - 2);
                    col_n   = rd_col;
                end
            end
            ST_WAIT: begin
                if (lat_q == '0) state_n = ST_PRE;
                else             lat_n   = lat_q - 1'b1;
            end
            ST_PRE: begin
                state_n = ST_BURST;
                idx_n   = '0;
            end
            ST_BURST: begin
                if (cut_now || idx_q == IW'(BL - 2)) state_n = ST_IDLE;
                else                                  idx_n   = idx_q + IW'(2);
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lat_q   <= '0;
            idx_q   <= '0;
            col_q   <= '0;
        end else begin
            state_q <= state_n;
            lat_q   <= lat_n;
            idx_q   <= idx_n;
            col_q   <= col_n;
        end
    end

    // Registered output enables and strobe levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_oe_q  <= 1'b0;
            dqs_oe_q <= 1'b0;
            dqs_q    <= STROBE_LOW;
        end else begin
            dq_oe_q  <= (state_n == ST_BURST);
            dqs_oe_q <= (state_n == ST_BURST) || (state_n == ST_PRE);
            dqs_q    <= (state_n == ST_BURST) ? STROBE_DATA : STROBE_LOW;
        end
    end

    // Run-length counter for the burst-length check
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= '0;
        else if (dq_oe_q) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    AST_DQ_NEEDS_DQS: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe_q |-> dqs_oe_q); // R3
    AST_PREAMBLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe_q) |-> ($past(dqs_oe_q) && $past(dqs_q) == STROBE_LOW)); // R2
    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe_q && $past(dq_oe_q)) |-> (idx_q == $past(idx_q) + IW'(2))); // R3
    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (IW+1)'(BEATS)); // R4

endmodule

// File: rtl/ddrrd_pad.sv
module ddrrd_pad #(
    parameter int N = 16
) (
    input  logic [N-1:0] d,
    input  logic         oe,
    output wire  [N-1:0] pad
);
    assign pad = oe ? d : {N{1'bz}};
endmodule

// File: rtl/ddr_read_burst_out.sv
module ddr_read_burst_out #(
    parameter int W  = 16,
    parameter int CL = 3,
    parameter int BL = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_cmd,
    input  logic         pre_cmd,
    input  logic [W-1:0] rd_col,
    output wire  [W-1:0] dq_rise_pad,
    output wire  [W-1:0] dq_fall_pad,
    output wire  [1:0]   dqs_pad,
    output logic         dq_oe,
    output logic         dqs_oe,
    output logic         pre_illegal
);
    localparam int IW = $clog2(BL);

    logic          live;
    logic          cut_now;
    logic [W-1:0]  col_q;
    logic [IW-1:0] idx_q;
    logic [1:0]    dqs_q;
    logic [W-1:0]  word_rise, word_fall;

    ddrrd_cut #(.CL(CL)) u_cut (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (live),
        .rd_cmd    (rd_cmd),
        .pre_cmd   (pre_cmd),
        .cut_now   (cut_now),
        .illegal_q (pre_illegal)
    );

    ddrrd_seq #(.W(W), .CL(CL), .BL(BL)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cmd   (rd_cmd),
        .rd_col   (rd_col),
        .cut_now  (cut_now),
        .live     (live),
        .col_q    (col_q),
        .idx_q    (idx_q),
        .dq_oe_q  (dq_oe),
        .dqs_oe_q (dqs_oe),
        .dqs_q    (dqs_q)
    );

    ddrrd_pattern #(.W(W), .IW(IW)) u_pat (
        .col       (col_q),
        .idx       (idx_q),
        .word_rise (word_rise),
        .word_fall (word_fall)
    );

    ddrrd_pad #(.N(W)) u_pad_rise (.d(word_rise), .oe(dq_oe),  .pad(dq_rise_pad));
    ddrrd_pad #(.N(W)) u_pad_fall (.d(word_fall), .oe(dq_oe),  .pad(dq_fall_pad));
    ddrrd_pad #(.N(2)) u_pad_dqs  (.d(dqs_q),     .oe(dqs_oe), .pad(dqs_pad));

    AST_ILLEGAL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pre_illegal |-> $past(rd_cmd && pre_cmd)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(live) && !$past(rd_cmd)) |-> !dqs_oe); // R8

endmodule

// File: tb/tb_ddr_read_burst_out.sv
`timescale 1ns/1ps
module tb_ddr_read_burst_out;
    localparam int W     = 16;
    localparam int CL    = 3;
    localparam int BL    = 8;
    localparam int BEATS = BL / 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_cmd = 1'b0;
    logic         pre_cmd = 1'b0;
    logic [W-1:0] rd_col = '0;
    wire  [W-1:0] dq_rise_pad, dq_fall_pad;
    wire  [1:0]   dqs_pad;
    logic         dq_oe, dqs_oe, pre_illegal;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    ddr_read_burst_out #(.W(W), .CL(CL), .BL(BL)) dut (
        .clk(clk), .rst_n(rst_n), .rd_cmd(rd_cmd), .pre_cmd(pre_cmd),
        .rd_col(rd_col), .dq_rise_pad(dq_rise_pad), .dq_fall_pad(dq_fall_pad),
        .dqs_pad(dqs_pad), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
        .pre_illegal(pre_illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One read on edge t; optional precharges at t+pre_d and t+pre2_d
    task automatic scen(input logic [W-1:0] col, input int pre_d, input int pre2_d,
                        input bit both, input bit rd_busy, input string tag);
        int stop;
        logic [W-1:0] er;
        stop = (pre_d >= 1 && pre_d < BEATS) ? pre_d + CL : CL + BEATS;
        @(negedge clk);
        rd_cmd  = 1'b1;
        rd_col  = col;
        pre_cmd = both;
        @(posedge clk);
        for (int c = 0; c <= CL + BEATS + 1; c++) begin
            @(negedge clk);
            rd_cmd  = 1'b0;
            pre_cmd = 1'b0;
            chk("R7", "pre_illegal", 32'(pre_illegal), 32'((c == 0) && both));
            if (c == CL - 1) begin
                chk("R2", "preamble dqs_oe", 32'(dqs_oe), 32'd1);
                chk("R2", "preamble dqs", 32'(dqs_pad), 32'd0);
                chk("R2", "preamble dq_oe", 32'(dq_oe), 32'd0);
            end else if (c >= CL && c < stop) begin
                er = col + W'(2 * (c - CL));
                chk(tag, "dq_oe", 32'(dq_oe), 32'd1);
                chk(tag, "dqs_oe", 32'(dqs_oe), 32'd1);
                chk(tag, "dqs", 32'(dqs_pad), 32'd2);
                chk(tag, "rise word", 32'(dq_rise_pad), 32'(er));
                chk(tag, "fall word", 32'(dq_fall_pad), 32'(er + W'(1)));
            end else begin
                chk(tag, "dq_oe off", 32'(dq_oe), 32'd0);
                chk(tag, "dqs_oe off", 32'(dqs_oe), 32'd0);
            end
            if (pre_d == c + 1 || pre2_d == c + 1) pre_cmd = 1'b1;
            if (rd_busy && c + 1 == 1) begin
                rd_cmd = 1'b1;
                rd_col = col + W'(100);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "dq_oe in reset", 32'(dq_oe), 32'd0);
        chk("R1", "dqs_oe in reset", 32'(dqs_oe), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "dq_oe after reset", 32'(dq_oe), 32'd0);
        chk("R1", "dqs_oe after reset", 32'(dqs_oe), 32'd0);
        chk("R1", "pre_illegal after reset", 32'(pre_illegal), 32'd0);

        // R3 R4 full bursts at several columns, including a wrapping one
        scen(16'h0000, 0, 0, 1'b0, 1'b0, "R3");
        scen(16'h1234, 0, 0, 1'b0, 1'b0, "R4");
        scen(16'hFFFC, 0, 0, 1'b0, 1'b0, "R3");

        // R5 / R6 sweep of precharge offsets
        for (int d = 1; d <= BEATS + 2; d++) begin
            scen(16'h0100 + W'(d * 16), d, 0, 1'b0, 1'b0, (d < BEATS) ? "R5" : "R6");
            scen(16'hFFFA, d, 0, 1'b0, 1'b0, (d < BEATS) ? "R5" : "R6");
        end

        // R7 precharge together with the read
        scen(16'h0ABC, 0, 0, 1'b1, 1'b0, "R7");

        // R9 read while busy, with and without a cut
        scen(16'h2000, 0, 0, 1'b0, 1'b1, "R9");
        scen(16'h3000, 2, 0, 1'b0, 1'b1, "R9");

        // R10 earliest precharge wins
        scen(16'h4000, 1, 2, 1'b0, 1'b0, "R10");
        scen(16'h5000, 2, 3, 1'b0, 1'b0, "R10");

        // R8 precharge while idle
        @(negedge clk);
        pre_cmd = 1'b1;
        @(negedge clk);
        pre_cmd = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R8", "idle pre dq_oe", 32'(dq_oe), 32'd0);
            chk("R8", "idle pre dqs_oe", 32'(dqs_oe), 32'd0);
            chk("R8", "idle pre flag", 32'(pre_illegal), 32'd0);
            @(negedge clk);
        end
        scen(16'h6000, 0, 0, 1'b0, 1'b0, "R8");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule